// File: doc/BRIEF.md
# Flash Program/Erase Operation Sequencer

This block sequences the long-running operations of a block-erasable flash array: single-byte writes, block erases and lock-bit changes. Each operation is modelled as a countdown whose length comes from a cycle-count input. The countdown stands in for the real pulse and verify algorithm. A failure-injection input lets the surrounding logic mark an operation as failed when it completes. The block drives a ready/busy output and an 8-bit status byte. The status byte shows readiness, the two suspend conditions and sticky error flags.

Erases and byte writes can be suspended and resumed. A suspend request does not stop the countdown at once. The operation keeps counting for a programmable latency and stops at the next countdown boundary. The remaining count is kept, so the total busy time of an operation does not change when it is suspended. While an erase is suspended, a byte write may be started, and that write may in turn be suspended. The erase cannot be resumed until the nested write has finished.

A power-down input aborts any running operation. During the abort, ready/busy is held low for a fixed number of cycles. After that, the output is held high with a cleared status while the input stays asserted. Every operation checks the programming-voltage flag once, when it starts. If the voltage is too low, the operation reports the fault and is refused without going busy.

Top module: `flash_op_sequencer`

## Requirements
- R1: After reset, `rdyBusy` is 1 and `status` is 0x80. Status bit layout:
  - bit 7: ready
  - bit 6: erase suspended
  - bit 5: erase error
  - bit 4: write/lock error
  - bit 3: programming-voltage error
  - bit 2: write suspended
  - bits 1:0: always 0
- R2: Starting an operation in idle with `vppOk` high makes `rdyBusy` and bit 7 read 0 for exactly N cycles, then 1 again. `opSel` selects the operation: 0 = byte write, 1 = erase, 2 = lock-bit. Code 3 is ignored. N is that operation's cycle-count input, and a count of 0 acts as 1.
- R3: A start with `vppOk` low never goes busy. It sets bit 3 and the operation's error bit: bit 5 for an erase, bit 4 for a write or lock.
- R4: If `failInject` is high on the completing cycle, bit 5 is set for an erase and bit 4 for a write or lock.
- R5: A suspend request to a running erase lets it run `suspLatency` + 1 further cycles. Then bits 7 and 6 read 1 and `rdyBusy` goes high. A resume clears bit 6 and drives `rdyBusy` low. The erase's total busy cycles still equal N. If the operation would finish first, it completes normally.
- R6: A suspend request to a running byte write works the same way, with bit 2 in place of bit 6. A resume clears bit 2 and bit 7.
- R7: A byte write started during an erase suspend drives bit 7 and `rdyBusy` low while bit 6 stays 1. That nested write can be suspended, which sets bits 6 and 2, and then resumed.
- R8: While an erase is suspended, a resume is ignored as long as a nested write is running, and erase or lock starts are ignored. Once the nested write is done, the erase stays suspended until a later resume.
- R9: Suspend requests have no effect on a lock-bit operation.
- R10: `pwrDown` during a running operation aborts it. `rdyBusy` is then low for exactly ABORT_CYCLES cycles, and afterwards reads 1 with status 0x80 for as long as `pwrDown` is held. Starts are ignored meanwhile. `pwrDown` in any non-running state gives status 0x80 on the next cycle.
- R11: `clearErr` clears bits 5:3. It is ignored while bit 6 or bit 2 is 1.
- R12: Starts are ignored while an operation is running or a top-level write is suspended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| opStart | input | 1 | Start strobe for the operation in `opSel` |
| opSel | input | 2 | 0 write, 1 erase, 2 lock-bit, 3 ignored |
| vppOk | input | 1 | Programming voltage is adequate |
| failInject | input | 1 | Marks the completing operation as failed |
| suspendReq | input | 1 | Suspend request strobe |
| resumeReq | input | 1 | Resume request strobe |
| clearErr | input | 1 | Clears the error flags |
| pwrDown | input | 1 | Functional reset / power-down hold |
| writeCycles | input | CNT_W | Byte write duration in cycles |
| eraseCycles | input | CNT_W | Erase duration in cycles |
| lockCycles | input | CNT_W | Lock-bit operation duration in cycles |
| suspLatency | input | CNT_W | Extra cycles before a suspend takes effect |
| rdyBusy | output | 1 | 1 = ready, 0 = operation actively running |
| status | output | 8 | Status byte laid out as in R1 |

## Verification
The hardest situation to reach is a byte write that is nested inside an erase suspend and is then suspended itself, with a resume request arriving while that write is running. Directed stimulus gets there in a fixed order: an erase is suspended, a nested write is started, a resume is pulsed during it, and a second nested write is suspended and resumed. The check is that the erase's busy cycles still add up to its count once it is finally resumed. Random stimulus then places suspend requests at varying distances from completion. A bench function predicts whether the latency window ends before the countdown does.

// File: rtl/fseq_pkg.sv
package fseq_pkg;

  typedef enum logic [1:0] {
    OP_WRITE = 2'd0,
    OP_ERASE = 2'd1,
    OP_LOCK  = 2'd2
  } opKind_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RUN,
    ST_ESUSP,
    ST_NWRITE,
    ST_WSUSP,
    ST_NWSUSP,
    ST_ABORT,
    ST_PDOWN
  } seqState_t;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic    loadOp;       // load active count for loadKind
    opKind_t loadKind;
    logic    restoreErase; // active count <= parked erase count
    logic    parkErase;    // parked erase count <= active count - 1
    logic    decActive;
    logic    armLat;
    logic    decLat;
    logic    loadAbort;
    logic    decAbort;
    logic    vppFault;     // voltage refused at start
    logic    finishOp;     // operation completes this cycle
    opKind_t faultKind;    // class of error for vppFault / finishOp
    logic    clearErr;
    logic    wipe;         // clear all error flags
  } seqStrobe_t;

endpackage

// File: rtl/fseq_datapath.sv
module fseq_datapath
  import fseq_pkg::*;
#(
  parameter int CNT_W        = 16,
  parameter int ABORT_CYCLES = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobe_t       stb,
  input  logic [CNT_W-1:0] writeCycles,
  input  logic [CNT_W-1:0] eraseCycles,
  input  logic [CNT_W-1:0] lockCycles,
  input  logic [CNT_W-1:0] suspLatency,
  input  logic             failInject,
  output logic             activeLast,
  output logic             latDone,
  output logic             abortLast,
  output logic [2:0]       errBits
);

  localparam int                 ABORT_W    = $clog2(ABORT_CYCLES + 1);
  localparam logic [ABORT_W-1:0] ABORT_INIT = ABORT_W'(ABORT_CYCLES);
  localparam logic [ABORT_W-1:0] ABORT_ONE  = ABORT_W'(1);
  localparam logic [CNT_W-1:0]   CNT_ONE    = CNT_W'(1);

  logic [CNT_W-1:0]   activeCnt;
  logic [CNT_W-1:0]   eraseSave;
  logic [CNT_W-1:0]   latCnt;
  logic [ABORT_W-1:0] abortCnt;
  logic [CNT_W-1:0]   selCnt;
  logic [2:0]         errNext;
  logic [2:0]         kindMask;

  // pick the duration of the operation being loaded; zero acts as one
  always_comb begin
    unique case (stb.loadKind)
      OP_ERASE: selCnt = eraseCycles;
      OP_LOCK:  selCnt = lockCycles;
      default:  selCnt = writeCycles;
    endcase
    if (selCnt == '0) selCnt = CNT_ONE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeCnt <= CNT_ONE;
    end else if (stb.loadOp) begin
      activeCnt <= selCnt;
    end else if (stb.restoreErase) begin
      activeCnt <= eraseSave;
    end else if (stb.decActive) begin
      activeCnt <= activeCnt - CNT_ONE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      eraseSave <= CNT_ONE;
    end else if (stb.parkErase) begin
      eraseSave <= activeCnt - CNT_ONE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latCnt <= '0;
    end else if (stb.armLat) begin
      latCnt <= suspLatency;
    end else if (stb.decLat) begin
      latCnt <= latCnt - CNT_ONE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      abortCnt <= ABORT_ONE;
    end else if (stb.loadAbort) begin
      abortCnt <= ABORT_INIT;
    end else if (stb.decAbort) begin
      abortCnt <= abortCnt - ABORT_ONE;
    end
  end

  assign activeLast = (activeCnt == CNT_ONE);
  assign latDone    = (latCnt == '0);
  assign abortLast  = (abortCnt <= ABORT_ONE);

  // errBits: [2] erase, [1] write/lock, [0] voltage
  assign kindMask = (stb.faultKind == OP_ERASE) ? 3'b100 : 3'b010;

  always_comb begin
    errNext = errBits;
    if (stb.clearErr) errNext = '0;
    if (stb.vppFault) errNext = errNext | kindMask | 3'b001;
    if (stb.finishOp && failInject) errNext = errNext | kindMask;
    if (stb.wipe) errNext = '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) errBits <= '0;
    else       errBits <= errNext;
  end

endmodule

// File: rtl/fseq_ctrl.sv
module fseq_ctrl
  import fseq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       opStart,
  input  logic [1:0] opSel,
  input  logic       vppOk,
  input  logic       suspendReq,
  input  logic       resumeReq,
  input  logic       clearErr,
  input  logic       pwrDown,
  input  logic       activeLast,
  input  logic       latDone,
  input  logic       abortLast,
  output seqStrobe_t stb,
  output logic       ready,
  output logic       eraseSusp,
  output logic       writeSusp
);

  seqState_t state, stateNext;
  opKind_t   curOp, curOpNext;
  logic      pending, pendingNext;
  logic      running;
  opKind_t   runKind;
  logic      selLegal;

  assign running  = (state == ST_RUN) || (state == ST_NWRITE);
  assign runKind  = (state == ST_NWRITE) ? OP_WRITE : curOp;
  assign selLegal = (opSel != 2'd3);

  assign ready     = !(running || state == ST_ABORT);
  assign eraseSusp = (state == ST_ESUSP) || (state == ST_NWRITE) || (state == ST_NWSUSP);
  assign writeSusp = (state == ST_WSUSP) || (state == ST_NWSUSP);

  always_comb begin
    stb         = '0;
    stateNext   = state;
    curOpNext   = curOp;
    pendingNext = pending;
    stb.clearErr = clearErr && !eraseSusp && !writeSusp;

    unique case (state)
      ST_IDLE: begin
        if (pwrDown) begin
          stateNext = ST_PDOWN;
          stb.wipe  = 1'b1;
        end else if (opStart && selLegal) begin
          stb.faultKind = opKind_t'(opSel);
          if (!vppOk) begin
            stb.vppFault = 1'b1;
          end else begin
            stb.loadOp   = 1'b1;
            stb.loadKind = opKind_t'(opSel);
            curOpNext    = opKind_t'(opSel);
            pendingNext  = 1'b0;
            stateNext    = ST_RUN;
          end
        end
      end

      ST_RUN, ST_NWRITE: begin
        if (pwrDown) begin
          stateNext     = ST_ABORT;
          stb.loadAbort = 1'b1;
          stb.wipe      = 1'b1;
          pendingNext   = 1'b0;
        end else if (activeLast) begin
          stb.finishOp  = 1'b1;
          stb.faultKind = runKind;
          pendingNext   = 1'b0;
          stateNext     = (state == ST_NWRITE) ? ST_ESUSP : ST_IDLE;
        end else if (pending) begin
          stb.decActive = 1'b1;
          if (latDone) begin
            pendingNext = 1'b0;
            if (state == ST_NWRITE) begin
              stateNext = ST_NWSUSP;
            end else if (curOp == OP_ERASE) begin
              stb.parkErase = 1'b1;
              stateNext     = ST_ESUSP;
            end else begin
              stateNext = ST_WSUSP;
            end
          end else begin
            stb.decLat = 1'b1;
          end
        end else begin
          stb.decActive = 1'b1;
          if (suspendReq && runKind != OP_LOCK) begin
            stb.armLat  = 1'b1;
            pendingNext = 1'b1;
          end
        end
      end

      ST_ESUSP: begin
        if (pwrDown) begin
          stateNext = ST_PDOWN;
          stb.wipe  = 1'b1;
        end else if (resumeReq) begin
          stb.restoreErase = 1'b1;
          stateNext        = ST_RUN;
        end else if (opStart && opSel == 2'd0) begin
          stb.faultKind = OP_WRITE;
          if (!vppOk) begin
            stb.vppFault = 1'b1;
          end else begin
            stb.loadOp   = 1'b1;
            stb.loadKind = OP_WRITE;
            pendingNext  = 1'b0;
            stateNext    = ST_NWRITE;
          end
        end
      end

      ST_WSUSP, ST_NWSUSP: begin
        if (pwrDown) begin
          stateNext = ST_PDOWN;
          stb.wipe  = 1'b1;
        end else if (resumeReq) begin
          stateNext = (state == ST_NWSUSP) ? ST_NWRITE : ST_RUN;
        end
      end

      ST_ABORT: begin
        if (abortLast) stateNext = pwrDown ? ST_PDOWN : ST_IDLE;
        else           stb.decAbort = 1'b1;
      end

      ST_PDOWN: begin
        if (!pwrDown) stateNext = ST_IDLE;
      end

      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      curOp   <= OP_WRITE;
      pending <= 1'b0;
    end else begin
      state   <= stateNext;
      curOp   <= curOpNext;
      pending <= pendingNext;
    end
  end

endmodule

// File: rtl/flash_op_sequencer.sv
module flash_op_sequencer
  import fseq_pkg::*;
#(
  parameter int CNT_W        = 16,
  parameter int ABORT_CYCLES = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             opStart,
  input  logic [1:0]       opSel,
  input  logic             vppOk,
  input  logic             failInject,
  input  logic             suspendReq,
  input  logic             resumeReq,
  input  logic             clearErr,
  input  logic             pwrDown,
  input  logic [CNT_W-1:0] writeCycles,
  input  logic [CNT_W-1:0] eraseCycles,
  input  logic [CNT_W-1:0] lockCycles,
  input  logic [CNT_W-1:0] suspLatency,
  output logic             rdyBusy,
  output logic [7:0]       status
);

  seqStrobe_t stb;
  logic       activeLast, latDone, abortLast;
  logic [2:0] errBits;
  logic       ready, eraseSusp, writeSusp;

  fseq_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .opStart    (opStart),
    .opSel      (opSel),
    .vppOk      (vppOk),
    .suspendReq (suspendReq),
    .resumeReq  (resumeReq),
    .clearErr   (clearErr),
    .pwrDown    (pwrDown),
    .activeLast (activeLast),
    .latDone    (latDone),
    .abortLast  (abortLast),
    .stb        (stb),
    .ready      (ready),
    .eraseSusp  (eraseSusp),
    .writeSusp  (writeSusp)
  );

  fseq_datapath #(
    .CNT_W        (CNT_W),
    .ABORT_CYCLES (ABORT_CYCLES)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .writeCycles (writeCycles),
    .eraseCycles (eraseCycles),
    .lockCycles  (lockCycles),
    .suspLatency (suspLatency),
    .failInject  (failInject),
    .activeLast  (activeLast),
    .latDone     (latDone),
    .abortLast   (abortLast),
    .errBits     (errBits)
  );

  assign rdyBusy = ready;
  assign status  = {ready, eraseSusp, errBits, writeSusp, 2'b00};

endmodule

// File: rtl/fseq_checker.sv
module fseq_checker (
  input logic       clk,
  input logic       rstN,
  input logic       pwrDown,
  input logic       rdyBusy,
  input logic [7:0] status
);

  // R5: entering erase suspend always shows ready
  p_esusp_ready_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(status[6]) |-> (rdyBusy && status[7]));

  // R6: entering a write suspend always shows ready
  p_wsusp_ready_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(status[2]) |-> (rdyBusy && status[7]));

  // R8: a running nested write never releases the erase suspend
  p_nested_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (status[6] && !status[7] && !pwrDown) |=> status[6]);

  // R3: a voltage refusal leaves the sequencer ready with an operation error
  p_vpp_reject_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(status[3]) |-> (rdyBusy && status[7] && (status[5] || status[4])));

  // R10: held power-down while ready stays ready with a cleared status
  p_pdown_ready_r10: assert property (@(posedge clk) disable iff (!rstN)
    (pwrDown && rdyBusy) |=> (rdyBusy && status == 8'h80));

endmodule

bind flash_op_sequencer fseq_checker u_fseq_checker (
  .clk     (clk),
  .rstN    (rstN),
  .pwrDown (pwrDown),
  .rdyBusy (rdyBusy),
  .status  (status)
);

// File: tb/flash_op_sequencer_bench.sv
`timescale 1ns/1ps
module flash_op_sequencer_bench;

  localparam int CNT_W = 16;
  localparam int ABORT_CYCLES = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic opStart = 1'b0;
  logic [1:0] opSel = 2'd0;
  logic vppOk = 1'b1;
  logic failInject = 1'b0;
  logic suspendReq = 1'b0;
  logic resumeReq = 1'b0;
  logic clearErr = 1'b0;
  logic pwrDown = 1'b0;
  logic [CNT_W-1:0] writeCycles = 16'd5;
  logic [CNT_W-1:0] eraseCycles = 16'd12;
  logic [CNT_W-1:0] lockCycles = 16'd3;
  logic [CNT_W-1:0] suspLatency = 16'd0;
  logic rdyBusy;
  logic [7:0] status;

  int checks = 0;
  int errors = 0;
  int busyTally = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  flash_op_sequencer #(.CNT_W(CNT_W), .ABORT_CYCLES(ABORT_CYCLES)) u_flash_op_sequencer (
    .clk(clk), .rstN(rstN), .opStart(opStart), .opSel(opSel), .vppOk(vppOk),
    .failInject(failInject), .suspendReq(suspendReq), .resumeReq(resumeReq),
    .clearErr(clearErr), .pwrDown(pwrDown), .writeCycles(writeCycles),
    .eraseCycles(eraseCycles), .lockCycles(lockCycles), .suspLatency(suspLatency),
    .rdyBusy(rdyBusy), .status(status)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    if (!rdyBusy) busyTally++;
  endtask

  task automatic waitReady();
    for (int i = 0; i < 2000 && !rdyBusy; i++) tick();
  endtask

  task automatic pulseStart(input int op);
    opSel = op[1:0]; opStart = 1'b1; tick(); opStart = 1'b0;
  endtask
  task automatic pulseSusp();
    suspendReq = 1'b1; tick(); suspendReq = 1'b0;
  endtask
  task automatic pulseResume();
    resumeReq = 1'b1; tick(); resumeReq = 1'b0;
  endtask
  task automatic pulseClear();
    clearErr = 1'b1; tick(); clearErr = 1'b0;
  endtask

  function automatic int effN(input int n);
    return (n == 0) ? 1 : n;
  endfunction
  function automatic int kindBit(input int op);
    return (op == 1) ? 8'h20 : 8'h10;
  endfunction
  function automatic int expStatus(input int op, input bit vpp, input bit fail);
    if (!vpp) return 8'h80 | 8'h08 | kindBit(op);
    return 8'h80 | (fail ? kindBit(op) : 0);
  endfunction
  // e = busy cycles seen when the request is raised, lat = latency
  function automatic bit predictSusp(input int op, input int n, input int e, input int lat);
    if (op == 2) return 1'b0;
    return (n - e - lat) >= 2;
  endfunction

  task automatic runOp(input string tag, input int op, input int expBusy, input int expSt);
    int t0;
    t0 = busyTally;
    pulseStart(op);
    waitReady();
    chk({tag, " busy"}, busyTally - t0, expBusy);
    chk({tag, " status"}, status, expSt);
  endtask

  initial begin
    int t0, t1, t2;
    void'($urandom(32'd20250607));
    repeat (3) @(negedge clk);
    chk("R1 reset ready", rdyBusy, 1);
    chk("R1 reset status", status, 8'h80);
    rstN = 1'b1;
    tick();
    chk("R1 after release", status, 8'h80);

    // R2 durations per operation, zero count, illegal code
    runOp("R2 write", 0, 5, 8'h80);
    runOp("R2 erase", 1, 12, 8'h80);
    runOp("R2 lock", 2, 3, 8'h80);
    lockCycles = 16'd0;
    runOp("R2 zero count", 2, 1, 8'h80);
    runOp("R2 code3 ignored", 3, 0, 8'h80);

    // R3 voltage refusal, R11 clear
    vppOk = 1'b0;
    runOp("R3 erase low vpp", 1, 0, 8'hA8);
    pulseClear();
    chk("R11 clear idle", status, 8'h80);
    runOp("R3 write low vpp", 0, 0, 8'h98);
    pulseClear();
    vppOk = 1'b1;

    // R4 failure injection
    failInject = 1'b1;
    runOp("R4 erase fail", 1, 12, 8'hA0);
    pulseClear();
    runOp("R4 write fail", 0, 5, 8'h90);
    pulseClear();
    lockCycles = 16'd3;
    runOp("R4 lock fail", 2, 3, 8'h90);
    pulseClear();
    failInject = 1'b0;

    // R5 erase suspend with latency 3
    eraseCycles = 16'd40; suspLatency = 16'd3;
    t0 = busyTally;
    pulseStart(1);
    repeat (5) tick();
    t1 = busyTally;
    pulseSusp();
    waitReady();
    chk("R5 suspend latency", busyTally - t1, 4);
    chk("R5 suspended status", status, 8'hC0);
    t2 = busyTally;
    repeat (6) tick();
    chk("R5 holds while suspended", busyTally - t2, 0);
    chk("R5 still suspended", status, 8'hC0);
    pulseResume();
    chk("R5 resume status", status, 8'h00);
    chk("R5 resume busy", rdyBusy, 0);
    waitReady();
    chk("R5 total busy", busyTally - t0, 40);
    chk("R5 final status", status, 8'h80);

    // R6 write suspend with latency 0, R12 start ignored while suspended
    writeCycles = 16'd30; suspLatency = 16'd0;
    t0 = busyTally;
    pulseStart(0);
    repeat (4) tick();
    t1 = busyTally;
    pulseSusp();
    waitReady();
    chk("R6 suspend latency", busyTally - t1, 1);
    chk("R6 suspended status", status, 8'h84);
    pulseStart(1);
    tick();
    chk("R12 start in write suspend", status, 8'h84);
    chk("R12 ready in write suspend", rdyBusy, 1);
    pulseResume();
    chk("R6 resume status", status, 8'h00);
    waitReady();
    chk("R6 total busy", busyTally - t0, 30);
    chk("R6 final status", status, 8'h80);

    // R7 / R8 nested write inside erase suspend
    eraseCycles = 16'd30; suspLatency = 16'd1;
    t0 = busyTally;
    pulseStart(1);
    repeat (2) tick();
    pulseSusp();
    waitReady();
    chk("R7 erase suspended", status, 8'hC0);
    pulseStart(1);
    tick();
    chk("R8 erase start ignored", status, 8'hC0);
    pulseStart(2);
    tick();
    chk("R8 lock start ignored", status, 8'hC0);
    writeCycles = 16'd8;
    t1 = busyTally;
    pulseStart(0);
    chk("R7 nested write status", status, 8'h40);
    chk("R7 nested write busy", rdyBusy, 0);
    pulseResume();
    waitReady();
    chk("R8 resume refused during nested write", status, 8'hC0);
    chk("R7 nested write length", busyTally - t1, 8);
    repeat (3) tick();
    chk("R8 erase stays suspended", status, 8'hC0);
    writeCycles = 16'd20;
    pulseStart(0);
    repeat (3) tick();
    pulseSusp();
    waitReady();
    chk("R7 nested write suspended", status, 8'hC4);
    pulseResume();
    chk("R7 nested write resumed", status, 8'h40);
    waitReady();
    chk("R7 back to erase suspend", status, 8'hC0);
    vppOk = 1'b0;
    pulseStart(0);
    chk("R3 nested low vpp", status, 8'hD8);
    pulseClear();
    chk("R11 clear ignored in suspend", status, 8'hD8);
    vppOk = 1'b1;
    pulseResume();
    chk("R8 erase resumed", status, 8'h18);
    waitReady();
    chk("R7 erase total busy", busyTally - t0, 30 + 8 + 20);
    chk("R7 erase done status", status, 8'h98);
    pulseClear();
    chk("R11 clear after suspend", status, 8'h80);

    // R9 lock ignores suspend
    lockCycles = 16'd10; suspLatency = 16'd0;
    t0 = busyTally;
    pulseStart(2);
    repeat (2) tick();
    pulseSusp();
    waitReady();
    chk("R9 lock busy", busyTally - t0, 10);
    chk("R9 lock status", status, 8'h80);

    // R12 start while running
    writeCycles = 16'd10;
    t0 = busyTally;
    pulseStart(0);
    repeat (3) tick();
    pulseStart(1);
    waitReady();
    chk("R12 busy unchanged", busyTally - t0, 10);
    chk("R12 status", status, 8'h80);

    // R10 abort
    eraseCycles = 16'd50;
    pulseStart(1);
    repeat (5) tick();
    pwrDown = 1'b1;
    t0 = busyTally;
    tick();
    waitReady();
    chk("R10 abort length", busyTally - t0, ABORT_CYCLES);
    chk("R10 held status", status, 8'h80);
    pulseStart(0);
    tick();
    chk("R10 start ignored while held", rdyBusy, 1);
    chk("R10 status while held", status, 8'h80);
    pwrDown = 1'b0;
    tick();
    vppOk = 1'b0;
    pulseStart(0);
    vppOk = 1'b1;
    chk("R3 error before power-down", status, 8'h98);
    pwrDown = 1'b1;
    tick();
    chk("R10 idle power-down clears", status, 8'h80);
    pwrDown = 1'b0;
    tick();

    // random mix
    suspLatency = 16'd2;
    for (int i = 0; i < 60; i++) begin
      int op, n, e, k;
      bit vpp, fail, doSusp, pred;
      op = $urandom % 3;
      n = $urandom % 20;
      vpp = ($urandom % 6) != 0;
      fail = $urandom % 2;
      doSusp = $urandom % 2;
      writeCycles = n[CNT_W-1:0];
      eraseCycles = n[CNT_W-1:0];
      lockCycles = n[CNT_W-1:0];
      vppOk = vpp;
      failInject = fail;
      pulseClear();
      t0 = busyTally;
      pulseStart(op);
      if (doSusp && vpp) begin
        k = $urandom % 4;
        repeat (k) tick();
        e = busyTally - t0;
        pulseSusp();
        waitReady();
        pred = predictSusp(op, effN(n), e, 2);
        chk((op == 2) ? "R9 random suspend" : "R5 R6 random suspend",
            int'(status[6] | status[2]), int'(pred));
        if (pred) pulseResume();
      end
      waitReady();
      chk("R2 random busy", busyTally - t0, vpp ? effN(n) : 0);
      chk("R4 random status", status, expStatus(op, vpp, fail));
    end
    failInject = 1'b0;
    vppOk = 1'b1;

    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule